// File: doc/BRIEF.md
# HDLC Serial Link Transmitter

This block drives a single serial data link with HDLC-style framing. While no message is pending it sends back-to-back flag octets. The controller fills a small transmit buffer, one octet per entry. It then writes a control byte that carries two things: a pointer to the last entry to send, and a start command. When the running octet ends, the block sends buffer entries from the first entry up to and including the pointed one. It sends each octet least significant bit first and inserts a zero bit after every five ones in a row. It can then append a two-octet check sequence, and it closes the frame with a flag.

The control byte also holds an abort command and a line-disable bit. Abort replaces the frame in progress with a run of ones and then returns to flags. Disable holds the line at one. The block raises an interrupt each time it takes a data octet from the buffer, so the controller knows to refill. Any write to the control byte clears that interrupt. A 16-bit read-back word returns the control byte in its low half and the interrupt in bit 14. The block emits one line bit per clock.

Top module: `hdlc_link_tx`

## Requirements
- R1: Following reset, `tx_bit` is 1, `tx_irq` is 0 and `ctl_rdata` reads 0x0000.
- R2: With the start bit (control bit 0) clear, the line carries continuous flag octets 0x7E and no frame.
- R3: Writing bit 0 = 1 with last-entry pointer P in bits 5:3 sends buffer entries 0..P in order, each LSB first, between an opening and a closing flag.
- R4: With control bit 1 set, two extra octets follow the data: the ones-complement of a CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) over the data, low octet first. With bit 1 clear, nothing follows the data.
- R5: Within data and check octets, a 0 is inserted after every five consecutive 1 bits, so an all-ones payload never looks like a flag or an abort.
- R6: Control bit 0 returns to 0 by itself once the closing flag begins.
- R7: Setting control bit 2 during a frame ends the frame at the next octet boundary with eight 1 bits, then flags resume. Bits 2 and 0 both read 0 afterwards, and no complete frame is delivered.
- R8: While control bit 6 is set, `tx_bit` is held at 1 from the clock edge after the write.
- R9: `tx_irq` (read-back bit 14) rises when a data octet is taken from the buffer and falls on the edge that captures any control write.
- R10: `ctl_rdata[7:0]` returns the last written control byte, including bit 7, which has no effect on transmission, apart from the self-clearing bits 0 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte value |
| ctl_rdata | output | 16 | Control byte in bits 7:0, interrupt in bit 14 |
| buf_wr | input | 1 | Buffer entry write strobe |
| buf_addr | input | 3 | Buffer entry index |
| buf_wdata | input | 8 | Buffer entry value |
| tx_bit | output | 1 | Serial line output |
| tx_irq | output | 1 | Transmit service request |

## Verification
The assertions rely on three rules about the controller's inputs. It does not change the pointer, the check-sequence bit or the buffer entries of a frame while that frame is being sent. It does not clear the start bit mid-frame unless it is aborting. It does not write the control byte on the cycle a frame ends. The stimulus follows these rules: it loads the buffer and writes the control byte only while the line is idle. The only writes during a frame are the interrupt acknowledge, issued right after the first data octet, and the abort. Both keep the start bit set. A bench-side receiver removes the inserted zeros and splits frames on flags and ones-runs. It checks octets, check sequences and abort detection against values computed from the requirements.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DATA,
      ST_FCS0,
      ST_FCS1,
      ST_ABORT
   } tx_state_e;

   localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
   localparam logic [7:0]  ABORT_OCTET = 8'hFF;
   localparam logic [15:0] CRC_POLY_R  = 16'h8408;
   localparam logic [15:0] CRC_PRESET  = 16'hFFFF;

   // one octet through the reflected CRC-16, low bit first
   function automatic logic [15:0] crc_octet(input logic [15:0] c_in, input logic [7:0] d);
      logic [15:0] c;
      logic        fb;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         fb = c[0] ^ d[i];
         c  = c >> 1;
         if (fb) c = c ^ CRC_POLY_R;
      end
      return c;
   endfunction

endpackage

// File: rtl/hdlc_tx_buf.sv
module hdlc_tx_buf #(
   parameter int DEPTH = 8,
   parameter int OCT_W = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [AW-1:0]    waddr,
   input  logic [OCT_W-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [OCT_W-1:0] rdata
);
   logic [OCT_W-1:0] ent_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                           ent_q[g] <= '0;
         else if (wr && waddr == AW'(g))       ent_q[g] <= wdata;
      end
   end

   assign rdata = ent_q[raddr];
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
   import hdlc_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   logic [15:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= CRC_PRESET;
      else if (start) crc_q <= crc_octet(CRC_PRESET, din);
      else if (upd)   crc_q <= crc_octet(crc_q, din);
   end

   assign crc = crc_q;
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
   import hdlc_tx_pkg::*;
#(
   parameter int OCT_W     = 8,
   parameter int STUFF_RUN = 5,
   localparam int CNT_W    = $clog2(OCT_W),
   localparam int ONES_W   = $clog2(STUFF_RUN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCT_W-1:0] ld_oct,
   input  logic             ld_stuff,
   output logic             ready,
   output logic             bit_out
);
   localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(OCT_W - 1);
   localparam logic [ONES_W-1:0] RUN_L    = ONES_W'(STUFF_RUN);

   logic [OCT_W-1:0]  sh_q;
   logic              stf_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ONES_W-1:0] ones_q;
   logic              bit_q;
   logic              stuff_now;

   assign stuff_now = (ones_q == RUN_L);
   assign ready     = !stuff_now && (cnt_q == LAST_BIT);
   assign bit_out   = bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= FLAG_OCTET;
         stf_q  <= 1'b0;
         cnt_q  <= '0;
         ones_q <= '0;
         bit_q  <= 1'b1;
      end else if (stuff_now) begin
         bit_q  <= 1'b0;
         ones_q <= '0;
      end else begin
         bit_q  <= sh_q[cnt_q];
         ones_q <= (stf_q && sh_q[cnt_q]) ? ones_q + 1'b1 : '0;
         if (ready) begin
            sh_q  <= ld_oct;
            stf_q <= ld_stuff;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // a full run of stuffable ones is always followed by a zero on the line
   assert_zero_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ones_q == RUN_L) |=> (!bit_out && ones_q == '0));
endmodule

// File: rtl/hdlc_link_tx.sv
module hdlc_link_tx
   import hdlc_tx_pkg::*;
#(
   parameter int BUF_DEPTH = 8,
   parameter int OCT_W     = 8,
   parameter int STUFF_RUN = 5,
   localparam int PTR_W    = $clog2(BUF_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_wdata,
   output logic [15:0]      ctl_rdata,
   input  logic             buf_wr,
   input  logic [PTR_W-1:0] buf_addr,
   input  logic [OCT_W-1:0] buf_wdata,
   output logic             tx_bit,
   output logic             tx_irq
);
   localparam int BIT_SEND  = 0;
   localparam int BIT_FCS   = 1;
   localparam int BIT_ABORT = 2;
   localparam int PTR_LSB   = 3;
   localparam int BIT_DIS   = 6;

   if (BUF_DEPTH < 2 || BUF_DEPTH > 8 || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("BUF_DEPTH must be a power of two from 2 to 8");
   end
   if (OCT_W != 8) begin : g_bad_oct
      $error("OCT_W must be 8");
   end
   if (STUFF_RUN < 1) begin : g_bad_run
      $error("STUFF_RUN must be positive");
   end

   logic [7:0]       ctrl_q;
   logic             irq_q;
   tx_state_e        st_q, st_d;
   logic [PTR_W-1:0] idx_q, idx_d;
   logic [PTR_W-1:0] rd_addr;
   logic [OCT_W-1:0] rd_oct;
   logic [15:0]      crc;
   logic [OCT_W-1:0] ld_oct;
   logic             ld_stuff, ready, ser_bit;
   logic             crc_start, crc_upd, irq_set, clr_send, clr_abort;
   logic             f_send, f_fcs, f_abort, f_dis;
   logic [PTR_W-1:0] f_ptr;

   assign f_send  = ctrl_q[BIT_SEND];
   assign f_fcs   = ctrl_q[BIT_FCS];
   assign f_abort = ctrl_q[BIT_ABORT];
   assign f_dis   = ctrl_q[BIT_DIS];
   assign f_ptr   = ctrl_q[PTR_LSB +: PTR_W];

   hdlc_tx_buf #(.DEPTH(BUF_DEPTH), .OCT_W(OCT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr(buf_wr), .waddr(buf_addr), .wdata(buf_wdata),
      .raddr(rd_addr), .rdata(rd_oct));

   hdlc_tx_fcs u_fcs (
      .clk(clk), .rst_n(rst_n), .start(crc_start), .upd(crc_upd), .din(rd_oct), .crc(crc));

   hdlc_tx_ser #(.OCT_W(OCT_W), .STUFF_RUN(STUFF_RUN)) u_ser (
      .clk(clk), .rst_n(rst_n), .ld_oct(ld_oct), .ld_stuff(ld_stuff),
      .ready(ready), .bit_out(ser_bit));

   assign rd_addr = (st_q == ST_IDLE) ? '0 : idx_q + 1'b1;

   always_comb begin
      st_d      = st_q;
      idx_d     = idx_q;
      ld_oct    = FLAG_OCTET;
      ld_stuff  = 1'b0;
      crc_start = 1'b0;
      crc_upd   = 1'b0;
      irq_set   = 1'b0;
      clr_send  = 1'b0;
      clr_abort = 1'b0;
      if (ready) begin
         unique case (st_q)
            ST_IDLE: begin
               if (f_abort) begin
                  clr_abort = 1'b1;
               end else if (f_send) begin
                  ld_oct    = rd_oct;
                  ld_stuff  = 1'b1;
                  crc_start = 1'b1;
                  irq_set   = 1'b1;
                  idx_d     = '0;
                  st_d      = ST_DATA;
               end
            end
            ST_DATA: begin
               if (f_abort) begin
                  ld_oct = ABORT_OCTET;
                  st_d   = ST_ABORT;
               end else if (idx_q != f_ptr) begin
                  ld_oct   = rd_oct;
                  ld_stuff = 1'b1;
                  crc_upd  = 1'b1;
                  irq_set  = 1'b1;
                  idx_d    = idx_q + 1'b1;
               end else if (f_fcs) begin
                  ld_oct   = ~crc[7:0];
                  ld_stuff = 1'b1;
                  st_d     = ST_FCS0;
               end else begin
                  clr_send = 1'b1;
                  st_d     = ST_IDLE;
               end
            end
            ST_FCS0: begin
               if (f_abort) begin
                  ld_oct = ABORT_OCTET;
                  st_d   = ST_ABORT;
               end else begin
                  ld_oct   = ~crc[15:8];
                  ld_stuff = 1'b1;
                  st_d     = ST_FCS1;
               end
            end
            ST_FCS1: begin
               if (f_abort) begin
                  ld_oct = ABORT_OCTET;
                  st_d   = ST_ABORT;
               end else begin
                  clr_send = 1'b1;
                  st_d     = ST_IDLE;
               end
            end
            default: begin
               clr_send  = 1'b1;
               clr_abort = 1'b1;
               st_d      = ST_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         ctrl_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         if (ctl_wr) begin
            ctrl_q <= ctl_wdata;
         end else begin
            if (clr_send)  ctrl_q[BIT_SEND]  <= 1'b0;
            if (clr_abort) ctrl_q[BIT_ABORT] <= 1'b0;
         end
         if (irq_set)     irq_q <= 1'b1;
         else if (ctl_wr) irq_q <= 1'b0;
      end
   end

   assign tx_bit    = ser_bit | f_dis;
   assign tx_irq    = irq_q;
   assign ctl_rdata = {1'b0, irq_q, 6'b000000, ctrl_q};

   // an idle boundary with a pending start and no abort begins at entry 0
   assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && ready && f_send && !f_abort) |=> (st_q == ST_DATA && idx_q == '0));

   // an abort seen at a data boundary moves to the ones run
   assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA && ready && f_abort) |=> (st_q == ST_ABORT));

   // the interrupt only appears together with a data octet load
   assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_irq) |-> (st_q == ST_DATA));

   // returning to idle leaves the start bit clear unless the controller wrote it
   assert_send_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) != ST_IDLE && st_q == ST_IDLE && !$past(ctl_wr)) |-> !ctl_rdata[BIT_SEND]);

   // a write that sets the disable bit forces the line high on the next cycle
   assert_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[BIT_DIS]) |=> tx_bit);
endmodule

// File: tb/sim_hdlc_link_tx.sv
`timescale 1ns/1ps
module sim_hdlc_link_tx;
   import hdlc_tx_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [15:0] ctl_rdata;
   logic        buf_wr = 1'b0;
   logic [2:0]  buf_addr = '0;
   logic [7:0]  buf_wdata = '0;
   logic        tx_bit, tx_irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hdlc_link_tx u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .tx_bit(tx_bit), .tx_irq(tx_irq));

   // bench-side receiver: zero removal, flag and abort detection
   int   r_ones = 0;
   int   r_nb = 0;
   logic r_bits [512];
   int   frames = 0, aborts = 0, flags = 0;
   logic [7:0] fr_bytes [16];
   int   fr_len = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_bit) begin
            r_ones++;
            if (r_nb < 512) begin r_bits[r_nb] = 1'b1; r_nb++; end
            if (r_ones == 7) begin aborts++; r_nb = 0; end
         end else begin
            if (r_ones == 5) begin
               // inserted zero, dropped
            end else if (r_ones == 6) begin
               flags++;
               r_nb = (r_nb >= 7) ? r_nb - 7 : 0;
               if (r_nb > 0 && r_nb % 8 == 0 && r_nb / 8 <= 16) begin
                  fr_len = r_nb / 8;
                  for (int k = 0; k < fr_len; k++)
                     for (int j = 0; j < 8; j++) fr_bytes[k][j] = r_bits[8*k + j];
                  frames++;
               end
               r_nb = 0;
            end else if (r_nb < 512) begin
               r_bits[r_nb] = 1'b0; r_nb++;
            end
            r_ones = 0;
         end
      end
   end

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: all requirements, actual cycles %0d expected below 100000", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic wr_buf(input int a, input logic [7:0] v);
      @(negedge clk); buf_wr = 1'b1; buf_addr = 3'(a); buf_wdata = v;
      @(negedge clk); buf_wr = 1'b0;
   endtask

   task automatic wait_frame(input int prev, input string req);
      int n = 0;
      while (frames == prev && n < 3000) begin @(posedge clk); n++; end
      @(negedge clk);
      chk(frames != prev, req, frames, prev + 1);
   endtask

   function automatic logic [15:0] ref_fcs(input logic [7:0] d [16], input int n);
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < n; k++)
         for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[k][i]) c = (c >> 1) ^ 16'h8408;
            else                c = c >> 1;
         end
      return ~c;
   endfunction

   task automatic test_reset();
      chk(tx_bit == 1'b1, "R1 line", int'(tx_bit), 1);
      chk(tx_irq == 1'b0, "R1 irq", int'(tx_irq), 0);
      chk(ctl_rdata == 16'h0000, "R1 readback", int'(ctl_rdata), 0);
   endtask

   task automatic test_idle();
      int f0 = flags, fr0 = frames;
      repeat (80) @(negedge clk);
      chk(flags - f0 >= 8, "R2 flag count", flags - f0, 8);
      chk(frames == fr0, "R2 no frame", frames, fr0);
   endtask

   task automatic test_frame(input int n, input bit fcs, input bit all_ones, input logic [7:0] seed);
      logic [7:0] exp [16];
      logic [15:0] f;
      int bad = 0, prev = frames, a0 = aborts;
      for (int k = 0; k < 16; k++) exp[k] = '0;
      for (int k = 0; k < n; k++) begin
         exp[k] = all_ones ? 8'hFF : 8'(seed + 8'(k * 37));
         wr_buf(k, exp[k]);
      end
      wr_ctl({2'b00, 3'(n - 1), 1'b0, fcs, 1'b1});
      wait_frame(prev, "R3 frame seen");
      chk(fr_len == n + (fcs ? 2 : 0), "R3/R4 frame length", fr_len, n + (fcs ? 2 : 0));
      for (int k = 0; k < n; k++) if (fr_bytes[k] != exp[k]) bad++;
      chk(bad == 0, "R3 data octets", bad, 0);
      if (fcs) begin
         f = ref_fcs(exp, n);
         chk({fr_bytes[n+1], fr_bytes[n]} == f, "R4 check sequence",
             int'({fr_bytes[n+1], fr_bytes[n]}), int'(f));
      end
      if (all_ones) chk(aborts == a0, "R5 no ones run of seven", aborts, a0);
      chk(ctl_rdata[0] == 1'b0, "R6 start self-clear", int'(ctl_rdata[0]), 0);
      chk(ctl_rdata[5:3] == 3'(n - 1), "R10 pointer readback", int'(ctl_rdata[5:3]), n - 1);
   endtask

   task automatic test_irq();
      int n = 0, prev;
      for (int k = 0; k < 4; k++) wr_buf(k, 8'h30 + 8'(k));
      prev = frames;
      wr_ctl(8'b0001_1011);
      while (!tx_irq && n < 200) begin @(posedge clk); n++; end
      @(negedge clk);
      chk(ctl_rdata[14] == 1'b1, "R9 irq raised", int'(ctl_rdata[14]), 1);
      wr_ctl(8'b0001_1011);
      chk(tx_irq == 1'b0, "R9 irq cleared by write", int'(tx_irq), 0);
      chk(ctl_rdata[14] == 1'b0, "R9 status bit cleared", int'(ctl_rdata[14]), 0);
      wait_frame(prev, "R9 frame after acknowledge");
      chk(fr_len == 6, "R9 frame length", fr_len, 6);
   endtask

   task automatic test_abort();
      int a0, fr0, fl0;
      for (int k = 0; k < 8; k++) wr_buf(k, 8'h55);
      a0 = aborts; fr0 = frames;
      wr_ctl(8'b0011_1011);
      repeat (30) @(negedge clk);
      wr_ctl(8'b0011_1111);
      repeat (40) @(negedge clk);
      chk(aborts > a0, "R7 ones run seen", aborts, a0 + 1);
      chk(frames == fr0, "R7 no frame delivered", frames, fr0);
      chk(ctl_rdata[2:0] == 3'b010, "R7 abort and start cleared", int'(ctl_rdata[2:0]), 2);
      fl0 = flags;
      repeat (40) @(negedge clk);
      chk(flags - fl0 >= 4, "R7 flags resume", flags - fl0, 4);
   endtask

   task automatic test_disable();
      int lows = 0, fl0;
      wr_ctl(8'h40);
      chk(ctl_rdata[7:0] == 8'h40, "R10 disable readback", int'(ctl_rdata[7:0]), 'h40);
      repeat (40) begin @(negedge clk); if (!tx_bit) lows++; end
      chk(lows == 0, "R8 line held high", lows, 0);
      wr_ctl(8'h00);
      fl0 = flags;
      repeat (40) @(negedge clk);
      chk(flags - fl0 >= 4, "R8 flags after enable", flags - fl0, 4);
   endtask

   task automatic test_rx_bit();
      int fr0 = frames;
      wr_ctl(8'h80);
      repeat (40) @(negedge clk);
      chk(ctl_rdata[7:0] == 8'h80, "R10 bit 7 readback", int'(ctl_rdata[7:0]), 'h80);
      chk(frames == fr0, "R10 bit 7 no frame", frames, fr0);
      wr_ctl(8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_idle();
      test_frame(3, 1'b1, 1'b0, 8'h1D);
      test_frame(1, 1'b0, 1'b0, 8'hA6);
      test_frame(8, 1'b1, 1'b0, 8'h42);
      test_frame(4, 1'b1, 1'b1, 8'h00);
      test_irq();
      test_abort();
      test_disable();
      test_rx_bit();
      repeat (20) @(negedge clk);
      done = 1'b1;
      summary();
   end
endmodule